// File: doc/BRIEF.md
# Boot Remap Address Decoder

This block sorts every processor access into one of a handful of destinations: the boot memory, the internal SRAM, the internal peripheral space, or one of the external-bus chip selects. The address space is cut into equal banks, and the decoder looks only at the bank number, which is the upper address bits. Out of reset, the lowest bank holds the exception vectors and routes to the boot device on chip select 0. Once software writes a one to the remap control bit, that same bank routes to the internal SRAM instead. After that, the other external chip selects become usable. Only a reset undoes the remap.

Inside the external-bus window, any bank with no chip select behind it is flagged with an abort. Any access to chip selects 1 and up made before the remap is flagged the same way. Internal space and peripheral space never abort, whether or not a bank there is populated. A boot mode pin is captured while reset is held and gives the width of the boot device. All decode outputs are registered, so they appear one clock after the valid strobe that produced them.

Top module: `boot_remap_decoder`

## Requirements
- R1: While reset is high, and on the first clock after it, all region selects, chip select enables, the abort flag and the remap state read zero.
- R2: Before remap, a valid access to bank 0 sets region select bit 0 (boot) and chip select enable bit 0, with no abort.
- R3: A register write with data bit 1 sets the remap state, and the remap state is visible on its output the clock after the write. After that, a bank 0 access sets region select bit 1 (SRAM) and no chip select.
- R4: A register write with data bit 0 leaves the remap state unchanged. Only reset clears a set remap state.
- R5: Each of the NUM_CS banks starting at bank EXT_FIRST maps to chip select k = bank - EXT_FIRST. After remap, an access there sets region select bit 3 (external) and chip select enable bit k.
- R6: Before remap, an access to a chip select bank with k >= 1 raises abort and sets no select. Chip select 0 in the external window is granted in both states.
- R7: A bank from EXT_FIRST+NUM_CS up to the first peripheral bank is undefined external space. An access there raises abort and sets no select.
- R8: The top PERIPH_BANKS banks set region select bit 2 (peripheral). Bank SRAM_BANK always sets region select bit 1. The other internal banks below EXT_FIRST set nothing. None of these ever raises abort.
- R9: Outputs follow the valid access by one clock. A clock without valid yields all-zero selects and no abort, so abort lasts one cycle for each offending access.
- R10: The boot width output takes the boot mode pin value (1 means an 8-bit device, 0 means a 16-bit device) while reset is high. After reset is released it holds that value regardless of the pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (internal or pin reset) |
| acc_valid | input | 1 | Access strobe |
| acc_bank | input | ADDR_W-BANK_SH | Upper address bits (bank number) of the access |
| ctl_wr | input | 1 | Remap control register write strobe |
| ctl_wdata | input | 1 | Remap control write data bit |
| boot_mode | input | 1 | Boot width pin, sampled during reset |
| region_sel | output | 4 | One-hot region: 0 boot, 1 SRAM, 2 peripheral, 3 external |
| cs_en | output | NUM_CS | One-hot chip select enables |
| abort | output | 1 | Undefined external access flag |
| remap_on | output | 1 | Remap state readback |
| boot_w8 | output | 1 | Latched boot width, 1 for 8-bit |

## Verification
The bench builds the decoder with ADDR_W=8 and BANK_SH=2, which gives 64 banks. Every bank value then fits into one sweep, so the whole map can be checked bank by bank before and after remap. With the default EXT_FIRST, NUM_CS and PERIPH_BANKS, this small map keeps every kind of region present: the low vector bank, undefined internal banks, the SRAM alias, all eight chip selects, a wide undefined external stretch and the peripheral top. It also covers each boundary between neighbouring kinds. Two reset cycles with opposite boot pin values cover the width latch.

// File: rtl/boot_remap_pkg.sv
package boot_remap_pkg;

  typedef enum logic [2:0] {
    RG_NONE   = 3'd0,
    RG_BOOT   = 3'd1,
    RG_SRAM   = 3'd2,
    RG_PERIPH = 3'd3,
    RG_EXT    = 3'd4,
    RG_UNDEF  = 3'd5
  } region_e;

  localparam int SEL_BOOT   = 0;
  localparam int SEL_SRAM   = 1;
  localparam int SEL_PERIPH = 2;
  localparam int SEL_EXT    = 3;
  localparam int SEL_W      = 4;

endpackage

// File: rtl/remap_ctl.sv
module remap_ctl (
  input  logic clk,
  input  logic rst,
  input  logic ctl_wr,
  input  logic ctl_wdata,
  input  logic boot_mode,
  output logic remap_q,
  output logic boot_w8_q
);

  // Remap is set-only; reset is the sole way back.
  always_ff @(posedge clk) begin
    if (rst)
      remap_q <= 1'b0;
    else if (ctl_wr && ctl_wdata)
      remap_q <= 1'b1;
  end

  // Boot width tracks the pin while reset is held, freezes on release.
  always_ff @(posedge clk) begin
    if (rst)
      boot_w8_q <= boot_mode;
  end

endmodule

// File: rtl/bank_classify.sv
module bank_classify
  import boot_remap_pkg::*;
#(
  parameter int BANK_W       = 12,
  parameter int NUM_CS       = 8,
  parameter int SRAM_BANK    = 3,
  parameter int EXT_FIRST    = 4,
  parameter int PERIPH_BANKS = 4
) (
  input  logic [BANK_W-1:0] bank,
  input  logic              remap,
  output region_e           region,
  output logic [NUM_CS-1:0] cs_hit
);

  localparam int NUM_BANKS   = 1 << BANK_W;
  localparam int PERIPH_LO   = NUM_BANKS - PERIPH_BANKS;
  localparam int EXT_CS_END  = EXT_FIRST + NUM_CS;

  genvar k;
  generate
    for (k = 0; k < NUM_CS; k++) begin : g_cs
      assign cs_hit[k] = (bank == BANK_W'(EXT_FIRST + k));
    end
  endgenerate

  always_comb begin
    region = RG_NONE;
    if (bank == '0)
      region = remap ? RG_SRAM : RG_BOOT;
    else if (bank == BANK_W'(SRAM_BANK))
      region = RG_SRAM;
    else if (bank < BANK_W'(EXT_FIRST))
      region = RG_NONE;
    else if (bank >= BANK_W'(PERIPH_LO))
      region = RG_PERIPH;
    else if (bank < BANK_W'(EXT_CS_END))
      region = RG_EXT;
    else
      region = RG_UNDEF;
  end

endmodule

// File: rtl/boot_remap_decoder.sv
module boot_remap_decoder
  import boot_remap_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int BANK_SH      = 20,
  parameter int NUM_CS       = 8,
  parameter int SRAM_BANK    = 3,
  parameter int EXT_FIRST    = 4,
  parameter int PERIPH_BANKS = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      acc_valid,
  input  logic [ADDR_W-BANK_SH-1:0] acc_bank,
  input  logic                      ctl_wr,
  input  logic                      ctl_wdata,
  input  logic                      boot_mode,
  output logic [3:0]                region_sel,
  output logic [NUM_CS-1:0]         cs_en,
  output logic                      abort,
  output logic                      remap_on,
  output logic                      boot_w8
);

  localparam int BANK_W = ADDR_W - BANK_SH;

  logic        remap_q;
  region_e     region;
  logic [NUM_CS-1:0] cs_hit;

  logic [SEL_W-1:0]  sel_d;
  logic [NUM_CS-1:0] cs_d;
  logic              abort_d;
  logic              hi_cs;

  remap_ctl u_ctl (
    .clk       (clk),
    .rst       (rst),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .boot_mode (boot_mode),
    .remap_q   (remap_q),
    .boot_w8_q (boot_w8)
  );

  bank_classify #(
    .BANK_W       (BANK_W),
    .NUM_CS       (NUM_CS),
    .SRAM_BANK    (SRAM_BANK),
    .EXT_FIRST    (EXT_FIRST),
    .PERIPH_BANKS (PERIPH_BANKS)
  ) u_cls (
    .bank   (acc_bank),
    .remap  (remap_q),
    .region (region),
    .cs_hit (cs_hit)
  );

  // Any chip select above 0 is withheld until remap.
  assign hi_cs = |cs_hit[NUM_CS-1:1];

  always_comb begin
    sel_d   = '0;
    cs_d    = '0;
    abort_d = 1'b0;
    if (acc_valid) begin
      unique case (region)
        RG_BOOT: begin
          sel_d[SEL_BOOT] = 1'b1;
          cs_d[0]         = 1'b1;
        end
        RG_SRAM:   sel_d[SEL_SRAM]   = 1'b1;
        RG_PERIPH: sel_d[SEL_PERIPH] = 1'b1;
        RG_EXT: begin
          if (hi_cs && !remap_q) begin
            abort_d = 1'b1;
          end else begin
            sel_d[SEL_EXT] = 1'b1;
            cs_d           = cs_hit;
          end
        end
        RG_UNDEF: abort_d = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      region_sel <= '0;
      cs_en      <= '0;
      abort      <= 1'b0;
    end else begin
      region_sel <= sel_d;
      cs_en      <= cs_d;
      abort      <= abort_d;
    end
  end

  assign remap_on = remap_q;

endmodule

// File: rtl/boot_remap_decoder_chk.sv
module boot_remap_decoder_chk #(
  parameter int NUM_CS = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic [3:0]        region_sel,
  input logic [NUM_CS-1:0] cs_en,
  input logic              abort,
  input logic              remap_on,
  input logic              boot_w8
);

  // R4
  remap_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !$fell(remap_on));

  // R10
  boot_width_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(boot_w8));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(acc_valid) |-> (region_sel == '0 && cs_en == '0 && !abort));

  // R7
  abort_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    abort |-> (region_sel == '0 && cs_en == '0));

  // R5
  onehot_sel_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(region_sel) && $onehot0(cs_en));

  // R6
  hi_cs_after_remap_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_en[NUM_CS-1:1] != '0) |-> remap_on);

  // R2
  boot_cs0_chk: assert property (@(posedge clk) disable iff (rst)
    region_sel[0] |-> (cs_en[0] && !remap_on));

endmodule

bind boot_remap_decoder boot_remap_decoder_chk #(.NUM_CS(NUM_CS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .acc_valid  (acc_valid),
  .region_sel (region_sel),
  .cs_en      (cs_en),
  .abort      (abort),
  .remap_on   (remap_on),
  .boot_w8    (boot_w8)
);

// File: tb/sim_boot_remap_decoder.sv
`timescale 1ns/1ps
module sim_boot_remap_decoder;

  localparam int ADDR_W = 8;
  localparam int BANK_SH = 2;
  localparam int BANK_W = ADDR_W - BANK_SH;
  localparam int NUM_CS = 8;
  localparam int SRAM_BANK = 3;
  localparam int EXT_FIRST = 4;
  localparam int PERIPH_BANKS = 4;
  localparam int NUM_BANKS = 1 << BANK_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic acc_valid = 1'b0;
  logic [BANK_W-1:0] acc_bank = '0;
  logic ctl_wr = 1'b0;
  logic ctl_wdata = 1'b0;
  logic boot_mode = 1'b0;
  logic [3:0] region_sel;
  logic [NUM_CS-1:0] cs_en;
  logic abort, remap_on, boot_w8;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  boot_remap_decoder #(
    .ADDR_W(ADDR_W), .BANK_SH(BANK_SH), .NUM_CS(NUM_CS),
    .SRAM_BANK(SRAM_BANK), .EXT_FIRST(EXT_FIRST), .PERIPH_BANKS(PERIPH_BANKS)
  ) u0 (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_bank(acc_bank),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .boot_mode(boot_mode),
    .region_sel(region_sel), .cs_en(cs_en), .abort(abort),
    .remap_on(remap_on), .boot_w8(boot_w8)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Expected {abort, cs[7:0], sel[3:0]} from the map rules.
  function automatic logic [12:0] expect_out(input int b, input bit rm);
    logic [3:0] s = '0;
    logic [7:0] c = '0;
    logic a = 1'b0;
    if (b == 0) begin
      if (rm) s[1] = 1'b1;
      else begin s[0] = 1'b1; c[0] = 1'b1; end
    end else if (b == SRAM_BANK) s[1] = 1'b1;
    else if (b < EXT_FIRST) ;
    else if (b >= NUM_BANKS - PERIPH_BANKS) s[2] = 1'b1;
    else if (b < EXT_FIRST + NUM_CS) begin
      if (b > EXT_FIRST && !rm) a = 1'b1;
      else begin s[3] = 1'b1; c[b - EXT_FIRST] = 1'b1; end
    end else a = 1'b1;
    return {a, c, s};
  endfunction

  function automatic string req_of(input int b, input bit rm);
    if (b == 0) return rm ? "R3" : "R2";
    if (b < EXT_FIRST || b >= NUM_BANKS - PERIPH_BANKS) return "R8";
    if (b < EXT_FIRST + NUM_CS) return (b > EXT_FIRST && !rm) ? "R6" : "R5";
    return "R7";
  endfunction

  task automatic access(input int b, input bit rm);
    @(negedge clk);
    acc_valid = 1'b1;
    acc_bank = BANK_W'(b);
    @(negedge clk);
    acc_valid = 1'b0;
    check(req_of(b, rm), {19'd0, abort, cs_en, region_sel}, {19'd0, expect_out(b, rm)});
  endtask

  task automatic ctl_write(input bit d);
    @(negedge clk);
    ctl_wr = 1'b1;
    ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 1'b0;
    ctl_wdata = 1'b0;
  endtask

  task automatic do_reset(input bit pin);
    @(negedge clk);
    boot_mode = pin;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {27'd0, abort, remap_on, |cs_en, |region_sel, 1'b0}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", {27'd0, abort, remap_on, |cs_en, |region_sel, 1'b0}, 32'd0);
    check("R10", {31'd0, boot_w8}, {31'd0, pin});
    boot_mode = ~pin;
    repeat (2) @(negedge clk);
    check("R10", {31'd0, boot_w8}, {31'd0, pin});
  endtask

  initial begin
    do_reset(1'b1);
    for (int b = 0; b < NUM_BANKS; b++) access(b, 1'b0);
    // R9: idle clock after an aborting access yields zeros
    access(EXT_FIRST + NUM_CS, 1'b0);
    @(negedge clk);
    check("R9", {19'd0, abort, cs_en, region_sel}, 32'd0);
    // R9: defined bank without valid produces nothing
    @(negedge clk);
    acc_bank = '0;
    @(negedge clk);
    check("R9", {19'd0, abort, cs_en, region_sel}, 32'd0);
    // R4: zero write ignored
    ctl_write(1'b0);
    check("R4", {31'd0, remap_on}, 32'd0);
    access(0, 1'b0);
    ctl_write(1'b1);
    check("R3", {31'd0, remap_on}, 32'd1);
    for (int b = 0; b < NUM_BANKS; b++) access(b, 1'b1);
    ctl_write(1'b0);
    check("R4", {31'd0, remap_on}, 32'd1);
    access(0, 1'b1);
    do_reset(1'b0);
    check("R4", {31'd0, remap_on}, 32'd0);
    access(0, 1'b0);
    access(EXT_FIRST + 1, 1'b0);
    access(EXT_FIRST, 1'b0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule